// File: doc/BRIEF.md
# Two-Master Bus Arbiter with Handoff Points

This block decides which of two masters drives a shared internal bus: a processor, which has the lowest priority, and a transfer controller that moves data on its own once activated. A request from the higher-priority master is not honoured at once. The bus changes hands only at safe points that the current owner reports through status inputs. For the processor, a safe point is the end of a bus cycle that is not part of a split access, or any cycle while it sleeps. For the transfer controller, a safe point is any cycle outside one of its four phases.

The arbiter can also hand the bus to an outside agent, but only once no external cycle is running. When nobody asks for the bus, the processor keeps it. A power-on reset clears everything at once. A manual reset keeps the current owner, stops all handoffs, and masks the wait input so that a running external cycle can finish.

Top module: `bus_handoff_arbiter`

## Requirements
- R1: While `por_n` is low, `owner` is 0 (processor), `gnt` is 2'b01 and `ext_back` is 0. This holds without waiting for a clock edge.
- R2: With no transfer-controller request and no release request, the processor keeps the bus.
- R3: While the processor owns the bus and `xc_act` is high, ownership moves to the transfer controller (`owner` 1, `gnt` 2'b10) at the first clock edge that ends a cycle with `cpu_cyc_end` high and `cpu_multi` low. No earlier edge moves it.
- R4: A cycle end with `cpu_multi` high is not a handoff point, so the processor keeps the bus.
- R5: While `cpu_sleep` is high, a pending request takes the bus at the next edge, with no cycle end needed.
- R6: A register-information phase (`xc_ph_kind` 1 = read, 3 = write) lasts RI_STATES cycles (default 3), starting in the cycle where `xc_ph_start` is high. The transfer controller keeps the grant through every one of those cycles, even with `xc_act` low.
- R7: A vector-read phase (kind 0) or data-transfer phase (kind 2) lasts from its start cycle through the cycle in which `xc_ph_done` is high. The grant is held through all of it.
- R8: Outside a phase, the transfer controller keeps the bus while `xc_act` is high. It returns the bus to the processor at the next edge once `xc_act` is low.
- R9: `ext_breq` gives the bus away (`owner` 2, `gnt` 2'b00, `ext_back` 1) only at the owner's handoff point and only while `ext_cyc_busy` is low. The processor gets the bus back at the edge after `ext_breq` falls.
- R10: While `mrst` is high, `owner` does not change and `wait_eff` is 0. Otherwise `wait_eff` follows `wait_in`.
- R11: Pulling `por_n` low in the middle of a phase gives the bus back to the processor at once.
- R12: `gnt` is always one-hot, except that it is 2'b00 exactly while `ext_back` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mrst | input | 1 | Manual reset: keeps state and freezes ownership |
| cpu_sleep | input | 1 | Processor is in sleep mode |
| cpu_cyc_end | input | 1 | Processor bus cycle ends in this clock |
| cpu_multi | input | 1 | Current processor access has further operations to come |
| xc_act | input | 1 | Transfer controller activation (bus request) |
| xc_ph_start | input | 1 | Transfer controller phase begins in this clock |
| xc_ph_kind | input | 2 | Phase kind: 0 vector, 1 info read, 2 data, 3 info write |
| xc_ph_done | input | 1 | Last clock of a vector or data phase |
| ext_breq | input | 1 | External bus release request |
| ext_cyc_busy | input | 1 | External bus cycle in progress |
| wait_in | input | 1 | Raw wait request from the external bus |
| gnt | output | 2 | Grant: bit 0 processor, bit 1 transfer controller |
| owner | output | 2 | Owner code: 0 processor, 1 transfer controller, 2 external |
| ext_back | output | 1 | Bus released to the outside agent |
| wait_eff | output | 1 | Wait as seen by the cycle logic, masked during manual reset |

## Verification
The bench holds a request while the processor signals split-access cycle ends, to catch an arbiter that hands over at any cycle boundary. It drops the controller's request in the first clock of a three-state information phase, which a design that counts the phase too short would release early. It also lets a vector or data phase end with a done pulse, where a design that treats the done cycle as outside the phase hands over one clock early. A release request is raised while an external cycle is still running, and a manual reset is raised with the request removed, so that any handoff during the freeze or any wait leaking through shows up at the ports.

// File: rtl/bha_pkg.sv
package bha_pkg;
    typedef enum logic [1:0] {
        OWN_CPU = 2'd0,
        OWN_XC  = 2'd1,
        OWN_EXT = 2'd2
    } owner_e;

    typedef enum logic [1:0] {
        PH_VEC   = 2'd0,
        PH_RI_RD = 2'd1,
        PH_DATA  = 2'd2,
        PH_RI_WR = 2'd3
    } phase_e;
endpackage

// File: rtl/bha_cpu_break.sv
module bha_cpu_break (
    input  logic cpu_sleep,
    input  logic cpu_cyc_end,
    input  logic cpu_multi,
    output logic cpu_brk
);
    // A sleeping processor yields at any cycle; otherwise only at a cycle
    // end that does not split a multi-operation access.
    always_comb begin
        cpu_brk = cpu_sleep | (cpu_cyc_end & ~cpu_multi);
    end
endmodule

// File: rtl/bha_xc_phase.sv
module bha_xc_phase
    import bha_pkg::*;
#(
    parameter int RI_STATES = 3
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ph_start,
    input  logic [1:0] ph_kind,
    input  logic       ph_done,
    output logic       in_phase
);
    localparam int CNT_W = (RI_STATES > 1) ? $clog2(RI_STATES) : 1;

    logic ri_kind;
    logic ri_busy;
    logic var_d, var_q;

    always_comb begin
        ri_kind = (phase_e'(ph_kind) == PH_RI_RD) || (phase_e'(ph_kind) == PH_RI_WR);
    end

    // Variable-length phases: busy from start until the done cycle.
    always_comb begin
        var_d = var_q;
        if (ph_done) begin
            var_d = 1'b0;
        end else if (ph_start && !ri_kind) begin
            var_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            var_q <= 1'b0;
        end else begin
            var_q <= var_d;
        end
    end

    // Fixed-length phases: the start cycle plus RI_STATES-1 counted cycles.
    generate
        if (RI_STATES > 1) begin : g_cnt
            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (ph_start && ri_kind) begin
                    cnt_d = CNT_W'(RI_STATES - 1);
                end else if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end

            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign ri_busy = (cnt_q != '0);
        end else begin : g_nocnt
            assign ri_busy = 1'b0;
        end
    endgenerate

    assign in_phase = ph_start | var_q | ri_busy;
endmodule

// File: rtl/bus_handoff_arbiter.sv
module bus_handoff_arbiter
    import bha_pkg::*;
#(
    parameter int RI_STATES = 3
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       mrst,
    input  logic       cpu_sleep,
    input  logic       cpu_cyc_end,
    input  logic       cpu_multi,
    input  logic       xc_act,
    input  logic       xc_ph_start,
    input  logic [1:0] xc_ph_kind,
    input  logic       xc_ph_done,
    input  logic       ext_breq,
    input  logic       ext_cyc_busy,
    input  logic       wait_in,
    output logic [1:0] gnt,
    output logic [1:0] owner,
    output logic       ext_back,
    output logic       wait_eff
);
    typedef struct packed {
        owner_e own;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    cpu_brk;
    logic    xc_in_phase;
    logic    ext_ok;

    bha_cpu_break u_cpu_brk (
        .cpu_sleep   (cpu_sleep),
        .cpu_cyc_end (cpu_cyc_end),
        .cpu_multi   (cpu_multi),
        .cpu_brk     (cpu_brk)
    );

    bha_xc_phase #(
        .RI_STATES (RI_STATES)
    ) u_xc_phase (
        .clk      (clk),
        .por_n    (por_n),
        .ph_start (xc_ph_start),
        .ph_kind  (xc_ph_kind),
        .ph_done  (xc_ph_done),
        .in_phase (xc_in_phase)
    );

    always_comb begin
        ext_ok = ext_breq & ~ext_cyc_busy;
        st_d   = st_q;
        if (!mrst) begin
            unique case (st_q.own)
                OWN_CPU: begin
                    if (cpu_brk) begin
                        if (ext_ok) begin
                            st_d.own = OWN_EXT;
                        end else if (xc_act) begin
                            st_d.own = OWN_XC;
                        end
                    end
                end
                OWN_XC: begin
                    if (!xc_in_phase) begin
                        if (ext_ok) begin
                            st_d.own = OWN_EXT;
                        end else if (!xc_act) begin
                            st_d.own = OWN_CPU;
                        end
                    end
                end
                OWN_EXT: begin
                    if (!ext_breq) begin
                        st_d.own = OWN_CPU;
                    end
                end
                default: st_d.own = OWN_CPU;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{own: OWN_CPU};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        owner    = st_q.own;
        gnt      = {st_q.own == OWN_XC, st_q.own == OWN_CPU};
        ext_back = (st_q.own == OWN_EXT);
        wait_eff = wait_in & ~mrst;
    end
endmodule

// File: rtl/bha_chk.sv
module bha_chk (
    input logic       clk,
    input logic       por_n,
    input logic       mrst,
    input logic       cpu_sleep,
    input logic       cpu_cyc_end,
    input logic       cpu_multi,
    input logic       xc_ph_start,
    input logic [1:0] xc_ph_kind,
    input logic       ext_breq,
    input logic       ext_cyc_busy,
    input logic [1:0] gnt,
    input logic [1:0] owner,
    input logic       ext_back,
    input logic       wait_eff
);
    // R12
    grant_shape_chk: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(gnt) && ((gnt == 2'b00) == ext_back));

    // R3
    cpu_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (owner == 2'd0 && !cpu_sleep && !(cpu_cyc_end && !cpu_multi)) |=> owner == 2'd0);

    // R6
    info_phase_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (owner == 2'd1 && xc_ph_start && xc_ph_kind[0]) |=> owner == 2'd1);

    // R9
    ext_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
        (owner != 2'd2 && ext_cyc_busy) |=> owner != 2'd2);

    // R9
    ext_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!ext_breq && !mrst) |=> owner != 2'd2);

    // R10
    mrst_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
        mrst |=> $stable(owner));

    // R10
    mrst_wait_chk: assert property (@(posedge clk) disable iff (!por_n)
        mrst |-> !wait_eff);
endmodule

bind bus_handoff_arbiter bha_chk u_bha_chk (
    .clk          (clk),
    .por_n        (por_n),
    .mrst         (mrst),
    .cpu_sleep    (cpu_sleep),
    .cpu_cyc_end  (cpu_cyc_end),
    .cpu_multi    (cpu_multi),
    .xc_ph_start  (xc_ph_start),
    .xc_ph_kind   (xc_ph_kind),
    .ext_breq     (ext_breq),
    .ext_cyc_busy (ext_cyc_busy),
    .gnt          (gnt),
    .owner        (owner),
    .ext_back     (ext_back),
    .wait_eff     (wait_eff)
);

// File: tb/bus_handoff_arbiter_bench.sv
module bus_handoff_arbiter_bench;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       mrst = 1'b0;
    logic       cpu_sleep = 1'b0;
    logic       cpu_cyc_end = 1'b0;
    logic       cpu_multi = 1'b0;
    logic       xc_act = 1'b0;
    logic       xc_ph_start = 1'b0;
    logic [1:0] xc_ph_kind = 2'd0;
    logic       xc_ph_done = 1'b0;
    logic       ext_breq = 1'b0;
    logic       ext_cyc_busy = 1'b0;
    logic       wait_in = 1'b0;
    logic [1:0] gnt;
    logic [1:0] owner;
    logic       ext_back;
    logic       wait_eff;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [1:0] own;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    bus_handoff_arbiter u_bus_handoff_arbiter (
        .clk          (clk),
        .por_n        (por_n),
        .mrst         (mrst),
        .cpu_sleep    (cpu_sleep),
        .cpu_cyc_end  (cpu_cyc_end),
        .cpu_multi    (cpu_multi),
        .xc_act       (xc_act),
        .xc_ph_start  (xc_ph_start),
        .xc_ph_kind   (xc_ph_kind),
        .xc_ph_done   (xc_ph_done),
        .ext_breq     (ext_breq),
        .ext_cyc_busy (ext_cyc_busy),
        .wait_in      (wait_in),
        .gnt          (gnt),
        .owner        (owner),
        .ext_back     (ext_back),
        .wait_eff     (wait_eff)
    );

    function automatic logic [1:0] gnt_of(input logic [1:0] o);
        case (o)
            2'd0:    gnt_of = 2'b01;
            2'd1:    gnt_of = 2'b10;
            default: gnt_of = 2'b00;
        endcase
    endfunction

    task automatic compare(input logic [1:0] eo, input string tag);
        logic       ew;
        logic [1:0] eg;
        ew = wait_in & ~mrst;
        eg = gnt_of(eo);
        n_chk++;
        if (owner !== eo || gnt !== eg || ext_back !== (eo == 2'd2) || wait_eff !== ew) begin
            n_fail++;
            $display("FAIL %s: owner=%0d gnt=%b back=%b wait=%b, expected owner=%0d gnt=%b back=%b wait=%b",
                     tag, owner, gnt, ext_back, wait_eff, eo, eg, eo == 2'd2, ew);
        end
    endtask

    // Driver side: inputs were set at this negedge; the expectation is for
    // the state after the coming posedge.
    task automatic step(input logic [1:0] eo, input string tag);
        exp_t e;
        e.own = eo;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: sample shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                compare(e.own, e.tag);
            end
        end
    end

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        compare(2'd0, "R1 reset state");
        @(negedge clk);
        por_n = 1'b1;

        // R2 parking with no requests
        step(2'd0, "R2 park");
        step(2'd0, "R2 park");
        step(2'd0, "R2 park");

        // R3 request waits for a cycle end
        xc_act = 1'b1;
        step(2'd0, "R3 no cycle end");
        step(2'd0, "R3 no cycle end");
        // R4 split access is not a break
        cpu_cyc_end = 1'b1; cpu_multi = 1'b1;
        step(2'd0, "R4 multi-part access");
        step(2'd0, "R4 multi-part access");
        cpu_multi = 1'b0;
        step(2'd1, "R3 handoff at boundary");
        cpu_cyc_end = 1'b0;

        // R6 info-read phase held for three states with request dropped
        xc_ph_start = 1'b1; xc_ph_kind = 2'd1; xc_act = 1'b0;
        step(2'd1, "R6 info state 1");
        xc_ph_start = 1'b0;
        step(2'd1, "R6 info state 2");
        step(2'd1, "R6 info state 3");
        step(2'd0, "R6 release after phase");

        // R5 sleeping processor yields at once
        cpu_sleep = 1'b1; xc_act = 1'b1;
        step(2'd1, "R5 sleep handoff");
        cpu_sleep = 1'b0;
        // R8 kept while request stays high
        step(2'd1, "R8 keep while active");
        step(2'd1, "R8 keep while active");
        xc_act = 1'b0;
        step(2'd0, "R8 return when idle");

        // R7 data phase held through done cycle
        cpu_sleep = 1'b1; xc_act = 1'b1;
        step(2'd1, "R7 acquire");
        cpu_sleep = 1'b0; xc_act = 1'b0; xc_ph_start = 1'b1; xc_ph_kind = 2'd2;
        step(2'd1, "R7 data start");
        xc_ph_start = 1'b0;
        step(2'd1, "R7 data busy");
        step(2'd1, "R7 data busy");
        xc_ph_done = 1'b1;
        step(2'd1, "R7 done cycle held");
        xc_ph_done = 1'b0;
        step(2'd0, "R7 release after done");

        // R9 external release waits for the external cycle
        ext_breq = 1'b1; ext_cyc_busy = 1'b1; cpu_cyc_end = 1'b1;
        step(2'd0, "R9 external cycle busy");
        step(2'd0, "R9 external cycle busy");
        ext_cyc_busy = 1'b0;
        step(2'd2, "R9 released");
        cpu_cyc_end = 1'b0;
        step(2'd2, "R9 stays released");
        ext_breq = 1'b0;
        step(2'd0, "R9 return to processor");

        // R10 manual reset freezes owner and masks wait
        xc_act = 1'b1; cpu_cyc_end = 1'b1; wait_in = 1'b1;
        step(2'd1, "R10 acquire, wait passes");
        cpu_cyc_end = 1'b0; xc_act = 1'b0; mrst = 1'b1;
        step(2'd1, "R10 frozen, wait masked");
        step(2'd1, "R10 frozen, wait masked");
        mrst = 1'b0; wait_in = 1'b0;
        step(2'd0, "R10 handoff after manual reset");

        // R11 power-on reset in the middle of a phase
        xc_act = 1'b1; cpu_cyc_end = 1'b1;
        step(2'd1, "R11 acquire");
        cpu_cyc_end = 1'b0; xc_ph_start = 1'b1; xc_ph_kind = 2'd3;
        step(2'd1, "R11 phase running");
        xc_ph_start = 1'b0;
        #1;
        por_n = 1'b0;
        #1;
        compare(2'd0, "R11 immediate abort");
        xc_act = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        step(2'd0, "R11 idle after reset");
        step(2'd0, "R11 idle after reset");

        #3;
        finish_run();
    end
endmodule